// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands in the common single-precision layout: 1 sign bit on top, 8 exponent bits with a bias of 127, and 23 fraction bits. Each operand is split into its fields. A normal operand gets its hidden 1 restored. A subnormal operand keeps a hidden 0 and is treated as having exponent 1. The two 24-bit significands produce a 48-bit product. The product is shifted left until its leading one is at the top, and the exponent is adjusted to match. The result is then rounded to nearest, ties to even, using guard, round and sticky bits. Finally the sign, exponent and fraction are packed back into 32 bits.

Special operands are resolved ahead of the arithmetic path:
- Any invalid combination gives one canonical quiet NaN.
- Infinities and zeros keep the XOR of the operand signs.
- A finite result whose exponent leaves the normal range at the top becomes a signed infinity and raises the overflow output.
- A result that falls below the smallest normal value is shifted down into the subnormal range, or to zero, before rounding.

The block has a single register stage. An operand pair sampled with `vld_i` high produces its result on the outputs after the next rising clock edge. The outputs keep that value until the next valid pair.

Top module: `spmul_core`

## Requirements
- R1: `res_vld_o` is high exactly in the cycle after a cycle with `vld_i` high. Reset (active low, asynchronous) clears `res_o`, `res_vld_o` and `ovf_o` to 0.
- R2: Apart from the invalid cases of R7, the result sign bit (bit 31) is the XOR of the operand sign bits.
- R3: For normal finite operands, the biased result exponent is the sum of the biased operand exponents minus 127, plus 1 when bit 47 of the 48-bit significand product is set. The leading one is removed and the next 23 bits form the fraction.
- R4: Rounding is to nearest with ties to even. The guard bit lies just below the 23 kept fraction bits, the round bit lies below the guard bit, and sticky is the OR of everything lower. The kept value is incremented when guard is 1 and at least one of round, sticky or the kept LSB is 1.
- R5: When rounding carries out of the 24-bit significand, the significand becomes 1.0 and the exponent is incremented.
- R6: A final biased exponent above 254 gives infinity (exponent field all ones, fraction 0) with the product sign and `ovf_o` = 1. In every other case `ovf_o` = 0.
- R7: A NaN operand (exponent all ones, fraction nonzero), or zero times infinity in either order, gives 0x7FC00000 with `ovf_o` = 0.
- R8: Infinity times a nonzero value, including another infinity, gives infinity with the product sign and `ovf_o` = 0.
- R9: Zero (exponent and fraction both 0) times a finite value gives a zero with the product sign.
- R10: A subnormal operand (exponent field 0, fraction nonzero) has a hidden 0 and exponent 1. A result below 2^-126 is right-shifted into the subnormal range before rounding under R4. It becomes zero when nothing survives the rounding. It becomes the smallest normal number when rounding carries into the hidden position.
- R11: While `vld_i` is low, `res_o` and `ovf_o` hold their previous values, whatever the operands do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| vld_i | input | 1 | Operand pair is valid this cycle |
| res_o | output | 32 | Registered product |
| res_vld_o | output | 1 | `res_o` carries a new product |
| ovf_o | output | 1 | The registered product overflowed to infinity |

## Verification
Every result (the product word, its valid strobe and the overflow flag) is due exactly one rising edge after the edge that samples `vld_i` high. There is no other latency anywhere in the block. The bench drives each operand pair on a falling edge and checks all three outputs on the following falling edge, half a period after they were registered. Back-to-back pairs are checked the same way, one per falling edge. For the hold behaviour, the bench changes the operands with `vld_i` low and rechecks the outputs on the falling edges that follow.

// File: rtl/spmul_pkg.sv
package spmul_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } op_cls_e;

endpackage

// File: rtl/spmul_unpack.sv
module spmul_unpack
  import spmul_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op_i,
  output logic                 sign_o,
  output logic [EXP_W-1:0]     exp_o,
  output logic [MAN_W:0]       sig_o,
  output op_cls_e              cls_o
);
  localparam int W = EXP_W + MAN_W + 1;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones, exp_zero, man_zero;

  assign sign_o   = op_i[W-1];
  assign exp_f    = op_i[W-2 -: EXP_W];
  assign man_f    = op_i[MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_zero = ~|man_f;

  // subnormals: hidden 0, effective exponent 1
  assign exp_o = exp_zero ? EXP_W'(1) : exp_f;
  assign sig_o = {~exp_zero, man_f};

  always_comb begin
    if (exp_ones)      cls_o = man_zero ? CLS_INF : CLS_NAN;
    else if (exp_zero) cls_o = man_zero ? CLS_ZERO : CLS_SUB;
    else               cls_o = CLS_NORM;
  end
endmodule

// File: rtl/spmul_norm.sv
module spmul_norm #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [MAN_W:0]                  sig_a_i,
  input  logic [MAN_W:0]                  sig_b_i,
  input  logic [EXP_W-1:0]                exp_a_i,
  input  logic [EXP_W-1:0]                exp_b_i,
  output logic [2*(MAN_W+1)-1:0]          prod_o,
  output logic signed [EXP_W+1:0]         exp_o
);
  localparam int SIG_W  = MAN_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int LZ_W   = $clog2(PROD_W);
  localparam int EW     = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  logic [PROD_W-1:0] prod;
  logic [LZ_W-1:0]   lz;

  assign prod = PROD_W'(sig_a_i) * PROD_W'(sig_b_i);

  // leading-zero count, highest set bit wins
  always_comb begin
    lz = '0;
    for (int i = 0; i < PROD_W; i++) begin
      if (prod[i]) lz = LZ_W'(PROD_W - 1 - i);
    end
  end

  assign prod_o = prod << lz;
  // leading one at top means exponent +1 relative to the 1.x position
  assign exp_o  = EW'({2'b00, exp_a_i}) + EW'({2'b00, exp_b_i})
                - EW'(BIAS) + EW'(1) - EW'(lz);
endmodule

// File: rtl/spmul_round.sv
module spmul_round #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                        sign_i,
  input  logic [2*(MAN_W+1)-1:0]      prod_i,
  input  logic signed [EXP_W+1:0]     exp_i,
  output logic [EXP_W+MAN_W:0]        res_o,
  output logic                        ovf_o
);
  localparam int SIG_W  = MAN_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EW     = EXP_W + 2;
  localparam int CAP    = PROD_W + 1;
  localparam int SH_W   = $clog2(CAP + 1);
  localparam logic signed [EW-1:0] ONE_S  = EW'(1);
  localparam logic signed [EW-1:0] CAP_S  = EW'(CAP);
  localparam logic signed [EW-1:0] MAXE_S = EW'((1 << EXP_W) - 2);

  logic                    sub;
  logic signed [EW-1:0]    diff;
  logic [SH_W-1:0]         sh;
  logic [2*PROD_W-1:0]     wide;
  logic [PROD_W-1:0]       shifted;
  logic                    lost;
  logic [SIG_W-1:0]        kept;
  logic                    g_bit, r_bit, s_bit, rnd;
  logic [SIG_W:0]          m_rnd;
  logic signed [EW-1:0]    exp_f;
  logic [MAN_W-1:0]        frac;

  assign sub  = exp_i < ONE_S;
  assign diff = ONE_S - exp_i;

  always_comb begin
    if (!sub)             sh = '0;
    else if (diff > CAP_S) sh = SH_W'(CAP);
    else                  sh = diff[SH_W-1:0];
  end

  // denormalizing shift keeps every dropped bit for sticky
  assign wide    = {prod_i, {PROD_W{1'b0}}} >> sh;
  assign shifted = wide[2*PROD_W-1:PROD_W];
  assign lost    = |wide[PROD_W-1:0];

  assign kept  = shifted[PROD_W-1 -: SIG_W];
  assign g_bit = shifted[PROD_W-1-SIG_W];
  assign r_bit = shifted[PROD_W-2-SIG_W];
  assign s_bit = (|shifted[PROD_W-3-SIG_W:0]) | lost;
  assign rnd   = g_bit & (r_bit | s_bit | kept[0]);
  assign m_rnd = {1'b0, kept} + (SIG_W+1)'(rnd);

  always_comb begin
    if (sub) begin
      exp_f = EW'(m_rnd[MAN_W]);
      frac  = m_rnd[MAN_W-1:0];
    end else if (m_rnd[SIG_W]) begin
      exp_f = exp_i + ONE_S;
      frac  = m_rnd[MAN_W:1];
    end else begin
      exp_f = exp_i;
      frac  = m_rnd[MAN_W-1:0];
    end
  end

  assign ovf_o = exp_f > MAXE_S;
  assign res_o = ovf_o ? {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}}
                       : {sign_i, exp_f[EXP_W-1:0], frac};
endmodule

// File: rtl/spmul_core.sv
module spmul_core
  import spmul_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  input  logic                 vld_i,
  output logic [EXP_W+MAN_W:0] res_o,
  output logic                 res_vld_o,
  output logic                 ovf_o
);
  localparam int W      = EXP_W + MAN_W + 1;
  localparam int SIG_W  = MAN_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EW     = EXP_W + 2;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-1:0]       ops  [2];
  logic               sgn  [2];
  logic [EXP_W-1:0]   exps [2];
  logic [SIG_W-1:0]   sigs [2];
  op_cls_e            cls  [2];

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_unp
    spmul_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp (
      .op_i  (ops[g]),
      .sign_o(sgn[g]),
      .exp_o (exps[g]),
      .sig_o (sigs[g]),
      .cls_o (cls[g])
    );
  end

  logic [PROD_W-1:0]     prod_n;
  logic signed [EW-1:0]  exp_n;
  logic [W-1:0]          rnd_res;
  logic                  rnd_ovf;
  logic                  p_sign;

  assign p_sign = sgn[0] ^ sgn[1];

  spmul_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .sig_a_i(sigs[0]),
    .sig_b_i(sigs[1]),
    .exp_a_i(exps[0]),
    .exp_b_i(exps[1]),
    .prod_o (prod_n),
    .exp_o  (exp_n)
  );

  spmul_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rnd (
    .sign_i(p_sign),
    .prod_i(prod_n),
    .exp_i (exp_n),
    .res_o (rnd_res),
    .ovf_o (rnd_ovf)
  );

  logic any_nan, any_inf, any_zero;
  logic [W-1:0] res_d;
  logic         ovf_d;

  assign any_nan  = (cls[0] == CLS_NAN)  || (cls[1] == CLS_NAN);
  assign any_inf  = (cls[0] == CLS_INF)  || (cls[1] == CLS_INF);
  assign any_zero = (cls[0] == CLS_ZERO) || (cls[1] == CLS_ZERO);

  always_comb begin
    ovf_d = 1'b0;
    if (any_nan || (any_inf && any_zero)) res_d = QNAN;
    else if (any_inf)                     res_d = {p_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (any_zero)                    res_d = {p_sign, {(W-1){1'b0}}};
    else begin
      res_d = rnd_res;
      ovf_d = rnd_ovf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      ovf_o     <= 1'b0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= vld_i;
      if (vld_i) begin
        res_o <= res_d;
        ovf_o <= ovf_d;
      end
    end
  end
endmodule

// File: rtl/spmul_core_chk.sv
module spmul_core_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [EXP_W+MAN_W:0] a_i,
  input logic [EXP_W+MAN_W:0] b_i,
  input logic                 vld_i,
  input logic [EXP_W+MAN_W:0] res_o,
  input logic                 res_vld_o,
  input logic                 ovf_o
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, inv, spec;
  assign a_nan  = (&a_i[W-2 -: EXP_W]) && (|a_i[MAN_W-1:0]);
  assign b_nan  = (&b_i[W-2 -: EXP_W]) && (|b_i[MAN_W-1:0]);
  assign a_inf  = (&a_i[W-2 -: EXP_W]) && !(|a_i[MAN_W-1:0]);
  assign b_inf  = (&b_i[W-2 -: EXP_W]) && !(|b_i[MAN_W-1:0]);
  assign a_zero = !(|a_i[W-2:0]);
  assign b_zero = !(|b_i[W-2:0]);
  assign inv    = a_nan || b_nan || (a_inf && b_zero) || (a_zero && b_inf);
  assign spec   = inv || a_inf || b_inf || a_zero || b_zero;

  AST_VLD_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) vld_i |=> res_vld_o); // R1
  AST_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !vld_i |=> !res_vld_o); // R1
  AST_SIGN_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !inv) |=> (res_o[W-1] == ($past(a_i[W-1]) ^ $past(b_i[W-1])))); // R2
  AST_OVF_INF: assert property (@(posedge clk_i) disable iff (!rst_ni) ovf_o |-> (res_o[W-2:0] == INF_MAG)); // R6
  AST_SPECIAL_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni) (vld_i && spec) |=> !ovf_o); // R6
  AST_INVALID_QNAN: assert property (@(posedge clk_i) disable iff (!rst_ni) (vld_i && inv) |=> (res_o == QNAN)); // R7
  AST_INF_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !inv && (a_inf || b_inf)) |=> (res_o[W-2:0] == INF_MAG)); // R8
  AST_ZERO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !inv && (a_zero || b_zero)) |=> (res_o[W-2:0] == '0)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(res_o) && $stable(ovf_o))); // R11
endmodule

bind spmul_core spmul_core_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .b_i      (b_i),
  .vld_i    (vld_i),
  .res_o    (res_o),
  .res_vld_o(res_vld_o),
  .ovf_o    (ovf_o)
);

// File: tb/spmul_core_tb.sv
`timescale 1ns/1ps
module spmul_core_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        vld_i = 1'b0;
  logic [31:0] res_o;
  logic        res_vld_o;
  logic        ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  spmul_core u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .vld_i(vld_i),
    .res_o(res_o), .res_vld_o(res_vld_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, check one rising edge later at the next falling edge
  task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] eres, input logic eovf);
    @(negedge clk_i);
    a_i = a; b_i = b; vld_i = 1'b1;
    @(negedge clk_i);
    vld_i = 1'b0;
    check({req, " result"}, res_o, eres);
    check({req, " ovf"}, {31'b0, ovf_o}, {31'b0, eovf});
    check("R1 valid", {31'b0, res_vld_o}, 32'd1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    check("R1 reset res", res_o, 32'h0);
    check("R1 reset vld", {31'b0, res_vld_o}, 32'd0);
    check("R1 reset ovf", {31'b0, ovf_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle vld", {31'b0, res_vld_o}, 32'd0);
  endtask

  task automatic t_normal;
    run("R3 1x1",       32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0);
    run("R3 2x3",       32'h40000000, 32'h40400000, 32'h40C00000, 1'b0);
    run("R3 1.5x1.5",   32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0);
    run("R2 -2x3",      32'hC0000000, 32'h40400000, 32'hC0C00000, 1'b0);
    run("R2 -2x-3",     32'hC0000000, 32'hC0400000, 32'h40C00000, 1'b0);
    run("R6 max no ovf", 32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 1'b0);
  endtask

  task automatic t_round;
    run("R4 tie odd up",    32'h3F800001, 32'h3FC00000, 32'h3FC00002, 1'b0);
    run("R4 tie even keep", 32'h3F800003, 32'h3FC00000, 32'h3FC00004, 1'b0);
    run("R4 sticky up",     32'h3F800001, 32'h3FC00001, 32'h3FC00003, 1'b0);
    run("R4 below half",    32'h3F800001, 32'h3F800001, 32'h3F800002, 1'b0);
  endtask

  task automatic t_carry;
    run("R5 carry", 32'h3FDA1700, 32'h3F964000, 32'h40000000, 1'b0);
  endtask

  task automatic t_overflow;
    run("R6 pos ovf", 32'h7F000000, 32'h40000000, 32'h7F800000, 1'b1);
    run("R6 neg ovf", 32'hFF000000, 32'h40000000, 32'hFF800000, 1'b1);
  endtask

  task automatic t_invalid;
    run("R7 qnan in",  32'h7FC00001, 32'h3F800000, 32'h7FC00000, 1'b0);
    run("R7 snan in",  32'h3F800000, 32'hFF800001, 32'h7FC00000, 1'b0);
    run("R7 0xinf",    32'h00000000, 32'hFF800000, 32'h7FC00000, 1'b0);
    run("R7 infx0",    32'h7F800000, 32'h80000000, 32'h7FC00000, 1'b0);
  endtask

  task automatic t_infinity;
    run("R8 -infx3",   32'hFF800000, 32'h40400000, 32'hFF800000, 1'b0);
    run("R8 infx-inf", 32'h7F800000, 32'hFF800000, 32'hFF800000, 1'b0);
    run("R8 infxsub",  32'h7F800000, 32'h00000001, 32'h7F800000, 1'b0);
  endtask

  task automatic t_zero;
    run("R9 -0x3",  32'h80000000, 32'h40400000, 32'h80000000, 1'b0);
    run("R9 0x-2",  32'h00000000, 32'hC0000000, 32'h80000000, 1'b0);
    run("R9 0x0",   32'h00000000, 32'h00000000, 32'h00000000, 1'b0);
  endtask

  task automatic t_underflow;
    run("R10 to sub",        32'h00800000, 32'h3F000000, 32'h00400000, 1'b0);
    run("R10 sub in",        32'h00000001, 32'h4B000000, 32'h00800000, 1'b0);
    run("R10 flush",         32'h80800000, 32'h00800000, 32'h80000000, 1'b0);
    run("R10 tie to 0",      32'h00000001, 32'h3F000000, 32'h00000000, 1'b0);
    run("R10 tie to 2",      32'h00000003, 32'h3F000000, 32'h00000002, 1'b0);
    run("R10 round to norm", 32'h007FFFFF, 32'h3F800001, 32'h00800000, 1'b0);
  endtask

  task automatic t_hold;
    run("R11 seed", 32'h7F000000, 32'h40000000, 32'h7F800000, 1'b1);
    a_i = 32'h3F800000; b_i = 32'h40000000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      a_i = a_i + 32'h00100000;
      check("R11 hold res", res_o, 32'h7F800000);
      check("R11 hold ovf", {31'b0, ovf_o}, 32'd1);
      check("R1 no vld", {31'b0, res_vld_o}, 32'd0);
    end
  endtask

  task automatic t_stream;
    @(negedge clk_i);
    a_i = 32'h40000000; b_i = 32'h40400000; vld_i = 1'b1;
    @(negedge clk_i);
    check("R1 stream 1", res_o, 32'h40C00000);
    check("R1 stream v1", {31'b0, res_vld_o}, 32'd1);
    a_i = 32'hC0000000; b_i = 32'h3F800000;
    @(negedge clk_i);
    check("R1 stream 2", res_o, 32'hC0000000);
    check("R1 stream v2", {31'b0, res_vld_o}, 32'd1);
    vld_i = 1'b0;
    @(negedge clk_i);
    check("R1 stream end", {31'b0, res_vld_o}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_round();
    t_carry();
    t_overflow();
    t_invalid();
    t_infinity();
    t_zero();
    t_underflow();
    t_hold();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule